// File: doc/BRIEF.md
# Segment Descriptor Address Lookup

This block keeps a small table of address segments. It answers, for any address it is given, which segment contains that address. Each entry describes a run of consecutive byte addresses by a base and a byte count. The entry also carries a two-part target index, made of a cluster number and a position within that cluster, and one bit that says whether a cache controller may cache accesses to the segment. An interconnect uses the index to steer a command toward its target, and a cache controller uses the bit to decide whether to cache the access.

A request is an address together with a request strobe. On the following clock edge the block presents a response strobe, a hit flag, the target index and the cacheable bit. Entries are loaded one at a time through a write port. Loading is accepted only in cycles with no lookup. Segments are expected to be disjoint. If software breaks that rule, the lowest-numbered matching entry supplies the answer and an overlap flag is raised beside it.

A two-state controller sequences the responses. `ST_IDLE` means no response is being presented. `ST_ANSWER` means the response registers hold the result of the lookup made in the previous cycle. There are four transitions:
- `ST_IDLE` to `ST_ANSWER` on a request.
- `ST_ANSWER` to `ST_ANSWER` on a back-to-back request.
- `ST_ANSWER` to `ST_IDLE` when no request follows.
- `ST_IDLE` to `ST_IDLE` while requests stay absent.

Top module: `seg_lookup`

## Requirements
- R1: An entry matches an address A exactly when base <= A <= base+size-1. Both end addresses hit, and the addresses one below the base and one past the end miss.
- R2: Every cycle with `lk_req` high produces `rsp_valid` high on the next cycle only. Back-to-back requests give back-to-back responses, and no response appears without a request.
- R3: On a hit, `rsp_hit` is 1 and `rsp_gidx`, `rsp_lidx` and `rsp_cache` equal the cluster index, local index and cacheable bit stored in the matching entry.
- R4: On a miss, `rsp_hit`, `rsp_gidx`, `rsp_lidx`, `rsp_cache` and `rsp_overlap` are all 0.
- R5: An entry loaded with size 0 never matches, even when its valid bit is 1.
- R6: An entry loaded with its valid bit at 0 never matches.
- R7: When several entries match, the one with the lowest entry number supplies the outputs and `rsp_overlap` is 1. With a single match, `rsp_overlap` is 0.
- R8: A write presented in the same cycle as `lk_req` is discarded and leaves the selected entry unchanged.
- R9: After reset `rsp_valid` is 0 and every entry is empty, so any lookup misses.
- R10: A segment ending at the top of the address space (base+size = 2^ADDR_W) matches its last address, and the range does not wrap around to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Load one table entry |
| wr_sel | input | IDX_W | Entry number to load |
| wr_base | input | ADDR_W | First byte address of the segment |
| wr_size | input | ADDR_W | Segment length in bytes, 0 means empty |
| wr_gidx | input | GIDX_W | Cluster part of the target index |
| wr_lidx | input | LIDX_W | Local part of the target index |
| wr_cache | input | 1 | Cacheable attribute |
| wr_valid | input | 1 | Entry in use |
| lk_req | input | 1 | Lookup strobe |
| lk_addr | input | ADDR_W | Address to look up |
| rsp_valid | output | 1 | Response present (one cycle after `lk_req`) |
| rsp_hit | output | 1 | Address lies in a segment |
| rsp_gidx | output | GIDX_W | Cluster index of the matching segment |
| rsp_lidx | output | LIDX_W | Local index of the matching segment |
| rsp_cache | output | 1 | Cacheable bit of the matching segment |
| rsp_overlap | output | 1 | More than one entry matched |

## Verification
The bench probes both edges of a segment and the addresses just outside them. A range compare that is off by one would either claim base+size or drop the last byte. It also places a segment at the very top of the address space, where a compare that computes base+size in the address width would wrap and either miss the last byte or hit address 0. Entries that are empty or marked invalid are looked up directly, and so is a write issued during a lookup; a design that ignored the size, the valid bit or the idle rule would report a hit there. Two overlapping entries check that the lower entry number wins and that the overlap flag is set. Back-to-back and isolated requests check that the response strobe neither stretches nor goes missing.

// File: rtl/seg_lookup_pkg.sv
package seg_lookup_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ANSWER = 1'b1
    } lk_state_e;

endpackage

// File: rtl/seg_entry.sv
module seg_entry #(
    parameter int ADDR_W = 32,
    parameter int GIDX_W = 4,
    parameter int LIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_size,
    input  logic [GIDX_W-1:0] wr_gidx,
    input  logic [LIDX_W-1:0] wr_lidx,
    input  logic              wr_cache,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              match,
    output logic [GIDX_W-1:0] gidx,
    output logic [LIDX_W-1:0] lidx,
    output logic              cache
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] size_q;
    logic              valid_q;
    logic [ADDR_W:0]   offset;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            size_q  <= '0;
            gidx    <= '0;
            lidx    <= '0;
            cache   <= 1'b0;
            valid_q <= 1'b0;
        end else if (we) begin
            base_q  <= wr_base;
            size_q  <= wr_size;
            gidx    <= wr_gidx;
            lidx    <= wr_lidx;
            cache   <= wr_cache;
            valid_q <= wr_valid;
        end
    end

    // Offset is taken one bit wider than the address so that an address
    // below the base shows up as a negative value, and a segment that ends
    // at the top of the address space cannot wrap around to zero.
    always_comb begin
        offset = {1'b0, lk_addr} - {1'b0, base_q};
        match  = valid_q && !offset[ADDR_W] && (offset[ADDR_W-1:0] < size_q);
    end

    // R8: stored contents change only through an accepted write
    p_hold_unless_written_r8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(base_q) && $stable(size_q) && $stable(valid_q))
    );

endmodule

// File: rtl/seg_prio.sv
module seg_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any,
    output logic         multi
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = req[i] && !seen[i];
        assign seen[i+1] = seen[i] || req[i];
    end

    always_comb begin
        any   = seen[N];
        multi = ($countones(req) > 1);
    end

    always_comb begin
        // R7: at most one winner, and only among the entries that matched
        p_single_grant_r7: assert ($onehot0(grant));
        p_grant_in_req_r7: assert ((grant & ~req) == '0);
    end

endmodule

// File: rtl/seg_lookup.sv
module seg_lookup
    import seg_lookup_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int ADDR_W    = 32,
    parameter int GIDX_W    = 4,
    parameter int LIDX_W    = 4,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_size,
    input  logic [GIDX_W-1:0] wr_gidx,
    input  logic [LIDX_W-1:0] wr_lidx,
    input  logic              wr_cache,
    input  logic              wr_valid,
    input  logic              lk_req,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [GIDX_W-1:0] rsp_gidx,
    output logic [LIDX_W-1:0] rsp_lidx,
    output logic              rsp_cache,
    output logic              rsp_overlap
);

    lk_state_e state_q, state_d;

    logic                 wr_accept;
    logic [N_ENTRIES-1:0] match_v;
    logic [N_ENTRIES-1:0] grant_v;
    logic                 any_hit;
    logic                 multi_hit;
    logic [GIDX_W-1:0]    g_arr [N_ENTRIES];
    logic [LIDX_W-1:0]    l_arr [N_ENTRIES];
    logic [N_ENTRIES-1:0] c_vec;
    logic [GIDX_W-1:0]    sel_gidx;
    logic [LIDX_W-1:0]    sel_lidx;
    logic                 sel_cache;

    // Writes land only in cycles with no lookup presented.
    assign wr_accept = wr_en && !lk_req;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_entry
        seg_entry #(
            .ADDR_W (ADDR_W),
            .GIDX_W (GIDX_W),
            .LIDX_W (LIDX_W)
        ) entry_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (wr_accept && (wr_sel == IDX_W'(i))),
            .wr_base  (wr_base),
            .wr_size  (wr_size),
            .wr_gidx  (wr_gidx),
            .wr_lidx  (wr_lidx),
            .wr_cache (wr_cache),
            .wr_valid (wr_valid),
            .lk_addr  (lk_addr),
            .match    (match_v[i]),
            .gidx     (g_arr[i]),
            .lidx     (l_arr[i]),
            .cache    (c_vec[i])
        );
    end

    seg_prio #(
        .N (N_ENTRIES)
    ) prio_i (
        .req   (match_v),
        .grant (grant_v),
        .any   (any_hit),
        .multi (multi_hit)
    );

    always_comb begin
        sel_gidx  = '0;
        sel_lidx  = '0;
        sel_cache = 1'b0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (grant_v[i]) begin
                sel_gidx  = sel_gidx | g_arr[i];
                sel_lidx  = sel_lidx | l_arr[i];
                sel_cache = sel_cache | c_vec[i];
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = lk_req ? ST_ANSWER : ST_IDLE;
            ST_ANSWER: state_d = lk_req ? ST_ANSWER : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_hit     <= 1'b0;
            rsp_gidx    <= '0;
            rsp_lidx    <= '0;
            rsp_cache   <= 1'b0;
            rsp_overlap <= 1'b0;
        end else if (lk_req) begin
            rsp_hit     <= any_hit;
            rsp_gidx    <= sel_gidx;
            rsp_lidx    <= sel_lidx;
            rsp_cache   <= sel_cache;
            rsp_overlap <= multi_hit;
        end else begin
            rsp_hit     <= 1'b0;
            rsp_gidx    <= '0;
            rsp_lidx    <= '0;
            rsp_cache   <= 1'b0;
            rsp_overlap <= 1'b0;
        end
    end

    assign rsp_valid = (state_q == ST_ANSWER);

    // R2: a response follows each request by exactly one cycle
    p_rsp_after_req_r2: assert property (
        @(posedge clk) disable iff (!rst_n)
        lk_req |=> rsp_valid
    );
    p_no_rsp_without_req_r2: assert property (
        @(posedge clk) disable iff (!rst_n)
        !lk_req |=> !rsp_valid
    );
    // R4: a miss drives every attribute to zero
    p_miss_is_zero_r4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_gidx == '0 && rsp_lidx == '0 && !rsp_cache && !rsp_overlap)
    );
    // R7: an overlap report implies a hit
    p_overlap_implies_hit_r7: assert property (
        @(posedge clk) disable iff (!rst_n)
        rsp_overlap |-> (rsp_hit && rsp_valid)
    );

endmodule

// File: tb/seg_lookup_tb_top.sv
`timescale 1ns/1ps
module seg_lookup_tb_top;

    localparam int N  = 8;
    localparam int AW = 32;
    localparam int GW = 4;
    localparam int LW = 4;

    typedef struct packed {
        logic          hit;
        logic [GW-1:0] g;
        logic [LW-1:0] l;
        logic          c;
        logic          ov;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_sel = '0;
    logic [AW-1:0] wr_base = '0;
    logic [AW-1:0] wr_size = '0;
    logic [GW-1:0] wr_gidx = '0;
    logic [LW-1:0] wr_lidx = '0;
    logic          wr_cache = 1'b0;
    logic          wr_valid = 1'b0;
    logic          lk_req = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          rsp_valid, rsp_hit, rsp_cache, rsp_overlap;
    logic [GW-1:0] rsp_gidx;
    logic [LW-1:0] rsp_lidx;

    int n_checks = 0;
    int n_fails  = 0;

    exp_t  expq[$];
    string tagq[$];

    logic [AW-1:0] m_base [N];
    logic [AW-1:0] m_size [N];
    logic [GW-1:0] m_g    [N];
    logic [LW-1:0] m_l    [N];
    logic          m_c    [N];
    logic          m_v    [N];

    always #2.5 clk = ~clk;

    seg_lookup dut_i (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_base (wr_base), .wr_size (wr_size),
        .wr_gidx (wr_gidx), .wr_lidx (wr_lidx), .wr_cache (wr_cache), .wr_valid (wr_valid),
        .lk_req (lk_req), .lk_addr (lk_addr),
        .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_gidx (rsp_gidx),
        .rsp_lidx (rsp_lidx), .rsp_cache (rsp_cache), .rsp_overlap (rsp_overlap)
    );

    function automatic exp_t model(input logic [AW-1:0] a);
        exp_t e;
        int   cnt;
        e   = '0;
        cnt = 0;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_size[i] != 0 &&
                longint'(a) >= longint'(m_base[i]) &&
                longint'(a) <  longint'(m_base[i]) + longint'(m_size[i])) begin
                if (cnt == 0) begin
                    e.hit = 1'b1; e.g = m_g[i]; e.l = m_l[i]; e.c = m_c[i];
                end
                cnt++;
            end
        end
        e.ov = (cnt > 1);
        return e;
    endfunction

    task automatic write_entry(input int sel, input logic [AW-1:0] b, input logic [AW-1:0] s,
                               input int g, input int l, input logic c, input logic v);
        @(negedge clk);
        lk_req = 1'b0; wr_en = 1'b1; wr_sel = 3'(sel); wr_base = b; wr_size = s;
        wr_gidx = GW'(g); wr_lidx = LW'(l); wr_cache = c; wr_valid = v;
        m_base[sel] = b; m_size[sel] = s; m_g[sel] = GW'(g); m_l[sel] = LW'(l);
        m_c[sel] = c; m_v[sel] = v;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input string tag);
        exp_t e;
        e = model(a);
        @(negedge clk);
        wr_en = 1'b0; lk_req = 1'b1; lk_addr = a;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    // R8: write and lookup in one cycle; the model is left untouched
    task automatic write_during_lookup(input int sel, input logic [AW-1:0] b, input logic [AW-1:0] s,
                                       input logic [AW-1:0] a);
        exp_t e;
        e = model(a);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_base = b; wr_size = s;
        wr_gidx = 4'd1; wr_lidx = 4'd1; wr_cache = 1'b1; wr_valid = 1'b1;
        lk_req = 1'b1; lk_addr = a;
        expq.push_back(e);
        tagq.push_back("R8");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0; lk_req = 1'b0;
        end
    endtask

    // Monitor: pops one expected item for every response the design presents
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            exp_t  e;
            exp_t  a;
            string t;
            n_checks++;
            a = {rsp_hit, rsp_gidx, rsp_lidx, rsp_cache, rsp_overlap};
            if (expq.size() == 0) begin
                n_fails++;
                $display("FAIL R2: response with no request, got %h expected none", a);
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                if (a !== e) begin
                    n_fails++;
                    $display("FAIL %s: {hit,g,l,c,ov} got %h expected %h", t, a, e);
                end
            end
        end
    end

    initial begin : watchdog
        #(5.0 * 100000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_g[i] = '0; m_l[i] = '0; m_c[i] = 1'b0; m_v[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R9: rsp_valid in reset got %b expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        lookup(32'h0000_1000, "R9");
        idle(1);

        write_entry(0, 32'h0000_1000, 32'h100, 1, 2, 1'b1, 1'b1);
        lookup(32'h0000_1000, "R1");
        lookup(32'h0000_10FF, "R1");
        lookup(32'h0000_1100, "R1");
        lookup(32'h0000_0FFF, "R4");
        idle(2);

        write_entry(3, 32'h0000_8000, 32'h40, 3, 5, 1'b0, 1'b1);
        lookup(32'h0000_8020, "R3");
        idle(1);
        lookup(32'h0000_1010, "R2");
        idle(3);
        lookup(32'h0000_803F, "R3");

        write_entry(5, 32'h0000_9000, 32'h0, 6, 6, 1'b1, 1'b1);
        lookup(32'h0000_9000, "R5");
        write_entry(6, 32'h0000_A000, 32'h10, 4, 4, 1'b1, 1'b0);
        lookup(32'h0000_A008, "R6");

        write_entry(7, 32'h0000_1080, 32'h100, 7, 7, 1'b0, 1'b1);
        lookup(32'h0000_1090, "R7");
        lookup(32'h0000_1150, "R7");

        write_during_lookup(2, 32'h0000_C000, 32'h10, 32'h0000_1000);
        lookup(32'h0000_C000, "R8");

        write_entry(4, 32'hFFFF_FF00, 32'h100, 2, 9, 1'b1, 1'b1);
        lookup(32'hFFFF_FFFF, "R10");
        lookup(32'hFFFF_FF00, "R10");
        lookup(32'h0000_0000, "R10");
        idle(4);

        n_checks++;
        if (expq.size() != 0) begin
            n_fails++;
            $display("FAIL R2: missing responses got %0d pending expected 0", expq.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule